// File: doc/BRIEF.md
# Dual-Mode Line Error Counter

This block counts line error events, one per cycle at most, in a saturating counter of `CNT_W` bits. A host reads it over a byte-wide port, half a count at a time. A mode input chooses how a stable value is presented for reading.

With the mode input low, the host owns the snapshot. It raises a freeze bit before reading. On the rising edge of that bit, the running count is captured into a snapshot and the running counter restarts from zero. While freeze stays high, reads return the captured value and new errors accumulate unseen. With freeze low, reads follow the running count.

With the mode input high, a single-cycle one-second strobe drives the cycle. Each strobe copies the count to the snapshot, restarts the counter and sets a sticky interrupt. For `GUARD_CYC` cycles after the strobe, reads are refused and flagged. The host reads the low half first. That read saves the upper half in a shadow register, so the following high read belongs to the same count.

Top module: `line_err_counter`

## Requirements
- R1: After reset the running count, snapshot, shadow half and interrupt are zero: a low read and a high read both return 0 and `sec_irq` is 0.
- R2: In host mode with `freeze` low, a low read (`rd_hi`=0) returns bits [BUS_W-1:0] of the number of cycles in which `err_evt` was high since the last clear.
- R3: In host mode a rising edge of `freeze` captures the running count into the snapshot and clears the running count. While `freeze` stays high, reads return the captured value unchanged whatever errors arrive. After `freeze` falls, reads show the errors counted since the edge.
- R4: An error in the same cycle as a clear (a `freeze` rising edge in host mode, or a strobe in periodic mode) is counted into the new interval, so the counter holds 1 after that edge.
- R5: The running count stops at all-ones and does not wrap.
- R6: In periodic mode each `tick_1s` pulse copies the running count into the snapshot and clears the running count. Until the next pulse, reads return that snapshot, regardless of further errors.
- R7: A `tick_1s` pulse in periodic mode sets `sec_irq` from the next cycle. `sec_irq` holds until a cycle with `irq_clr` high and no pulse; a pulse wins over a simultaneous clear. In host mode `tick_1s` neither sets `sec_irq` nor clears the count.
- R8: A valid low read stores the upper half of the readable value in a shadow register. A high read (`rd_hi`=1) returns that shadow, even if the count has changed since the low read.
- R9: In the `GUARD_CYC` cycles that follow a periodic update, any read drives `rd_invalid` high and `rd_data` to 0, and it leaves the shadow register unchanged. The first read after that window is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_mode | input | 1 | 0 = host freeze scheme, 1 = periodic one-second scheme |
| freeze | input | 1 | Host freeze bit; its rising edge clears the counter in host mode |
| tick_1s | input | 1 | Single-cycle one-second strobe |
| err_evt | input | 1 | One error event per cycle when high |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| rd_hi | input | 1 | 0 = low half (also loads the shadow), 1 = high half from the shadow |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| rd_data | output | BUS_W | Read data, 0 when idle or refused |
| rd_invalid | output | 1 | Read fell inside the guard window and was refused |
| sec_irq | output | 1 | Sticky one-second interrupt flag |

## Verification
The assertions assume that `tick_1s` is a single-cycle strobe. They also assume that the host does not change `per_mode` while a freeze is held or a guard window is running, and that `freeze` is held low or steady during reset. The stimulus changes `per_mode` only once, while `freeze` is low and no guard is active. Each strobe is followed by idle or read cycles that span the full guard window before the next one. Inputs change only at the falling clock edge.

// File: rtl/errc_pkg.sv
package errc_pkg;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;

endpackage

// File: rtl/errc_live.sv
module errc_live #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ALL_ONES = '1;

   logic [W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt == ALL_ONES) ? cnt : cnt + W'(1);
      end else begin : g_wrap
         assign cnt_inc = cnt + W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= W'(evt);
      end else if (evt) begin
         cnt <= cnt_inc;
      end
   end
endmodule

// File: rtl/errc_snap.sv
module errc_snap #(
   parameter int W         = 16,
   parameter int GUARD_CYC = 250
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         per_mode,
   input  logic         freeze,
   input  logic         tick_1s,
   input  logic         irq_clr,
   input  logic [W-1:0] live_cnt,
   output logic         clr_live,
   output logic [W-1:0] view,
   output logic         guard,
   output logic         sec_irq
);
   localparam int GW = $clog2(GUARD_CYC + 1);

   logic          freeze_q;
   logic          frz_rise;
   logic          per_upd;
   logic [W-1:0]  snap;
   logic [GW-1:0] gcnt;

   assign frz_rise = ~per_mode & freeze & ~freeze_q;
   assign per_upd  = per_mode & tick_1s;
   assign clr_live = frz_rise | per_upd;
   assign guard    = (gcnt != '0);
   assign view     = (~per_mode & ~(freeze & freeze_q)) ? live_cnt : snap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freeze_q <= 1'b0;
         snap     <= '0;
         gcnt     <= '0;
         sec_irq  <= 1'b0;
      end else begin
         freeze_q <= freeze;
         if (clr_live) begin
            snap <= live_cnt;
         end
         if (per_upd) begin
            gcnt <= GW'(GUARD_CYC);
         end else if (guard) begin
            gcnt <= gcnt - GW'(1);
         end
         if (per_upd) begin
            sec_irq <= 1'b1;
         end else if (irq_clr) begin
            sec_irq <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/errc_rdport.sv
module errc_rdport
   import errc_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic            rd_hi,
   input  logic            guard,
   input  logic [2*BW-1:0] view,
   output logic [BW-1:0]   rd_data,
   output logic            rd_invalid
);
   half_sel_e     sel;
   logic          rd_ok;
   logic [BW-1:0] shadow;

   assign sel        = half_sel_e'(rd_hi);
   assign rd_invalid = rd_en & guard;
   assign rd_ok      = rd_en & ~guard;

   always_comb begin
      rd_data = '0;
      if (rd_ok) begin
         rd_data = (sel == HALF_HI) ? shadow : view[BW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (rd_ok && sel == HALF_LO) begin
         shadow <= view[2*BW-1:BW];
      end
   end
endmodule

// File: rtl/line_err_counter.sv
module line_err_counter #(
   parameter int CNT_W     = 16,
   parameter int BUS_W     = 8,
   parameter int GUARD_CYC = 250,
   parameter bit SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             per_mode,
   input  logic             freeze,
   input  logic             tick_1s,
   input  logic             err_evt,
   input  logic             rd_en,
   input  logic             rd_hi,
   input  logic             irq_clr,
   output logic [BUS_W-1:0] rd_data,
   output logic             rd_invalid,
   output logic             sec_irq
);
   localparam int HALVES = CNT_W / BUS_W;

   initial begin
      assert (HALVES == 2 && CNT_W % BUS_W == 0)
         else $error("line_err_counter: CNT_W must be twice BUS_W");
      assert (GUARD_CYC >= 1)
         else $error("line_err_counter: GUARD_CYC must be at least 1");
   end

   logic [CNT_W-1:0] live_cnt;
   logic [CNT_W-1:0] view;
   logic             clr_live;
   logic             guard;

   errc_live #(.W(CNT_W), .SATURATE(SATURATE)) u_live (
      .clk (clk),
      .rst_n (rst_n),
      .evt (err_evt),
      .clr (clr_live),
      .cnt (live_cnt)
   );

   errc_snap #(.W(CNT_W), .GUARD_CYC(GUARD_CYC)) u_snap (
      .clk (clk),
      .rst_n (rst_n),
      .per_mode (per_mode),
      .freeze (freeze),
      .tick_1s (tick_1s),
      .irq_clr (irq_clr),
      .live_cnt (live_cnt),
      .clr_live (clr_live),
      .view (view),
      .guard (guard),
      .sec_irq (sec_irq)
   );

   errc_rdport #(.BW(BUS_W)) u_rd (
      .clk (clk),
      .rst_n (rst_n),
      .rd_en (rd_en),
      .rd_hi (rd_hi),
      .guard (guard),
      .view (view),
      .rd_data (rd_data),
      .rd_invalid (rd_invalid)
   );
endmodule

// File: rtl/errc_chk.sv
module errc_chk #(
   parameter int CNT_W    = 16,
   parameter int BUS_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             per_mode,
   input logic             freeze,
   input logic             tick_1s,
   input logic             err_evt,
   input logic             rd_en,
   input logic             rd_hi,
   input logic             irq_clr,
   input logic [BUS_W-1:0] rd_data,
   input logic             rd_invalid,
   input logic             sec_irq,
   input logic [CNT_W-1:0] live_cnt,
   input logic             clr_live
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      per_mode && tick_1s |=> sec_irq);

   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sec_irq && !irq_clr |=> sec_irq);

   a_r9_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rd_invalid |-> rd_data == '0);

   a_r9_guard_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(per_mode && tick_1s) && rd_en |-> rd_invalid);

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      SATURATE && live_cnt == ALL_ONES && !clr_live |=> live_cnt == ALL_ONES);

   a_r4_clear_keeps_evt: assert property (@(posedge clk) disable iff (!rst_n)
      clr_live |=> live_cnt == CNT_W'($past(err_evt)));

   a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !per_mode && freeze && $past(freeze) && $past(!per_mode)
      && rd_en && !rd_hi && !rd_invalid
      && $past(rd_en && !rd_hi && !rd_invalid) |-> $stable(rd_data));
endmodule

bind line_err_counter errc_chk #(
   .CNT_W(CNT_W), .BUS_W(BUS_W), .SATURATE(SATURATE)
) i_chk (.*);

// File: tb/test_line_err_counter.sv
`timescale 1ns/1ps
module test_line_err_counter;
   localparam int BW  = 4;
   localparam int CW  = 8;
   localparam int G   = 5;
   localparam int TOP = 255;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          per_mode = 1'b0, freeze = 1'b0, tick_1s = 1'b0, err_evt = 1'b0;
   logic          rd_en = 1'b0, rd_hi = 1'b0, irq_clr = 1'b0;
   logic [BW-1:0] rd_data;
   logic          rd_invalid, sec_irq;

   int n_chk = 0, n_err = 0;
   int m_live = 0, m_snap = 0, m_shadow = 0, m_g = 0;
   logic m_irq = 1'b0, m_frzq = 1'b0;
   int s_data;
   logic s_inv, s_irq;

   always #2 clk = ~clk;

   line_err_counter #(.CNT_W(CW), .BUS_W(BW), .GUARD_CYC(G)) i_line_err_counter (
      .clk(clk), .rst_n(rst_n), .per_mode(per_mode), .freeze(freeze),
      .tick_1s(tick_1s), .err_evt(err_evt), .rd_en(rd_en), .rd_hi(rd_hi),
      .irq_clr(irq_clr), .rd_data(rd_data), .rd_invalid(rd_invalid),
      .sec_irq(sec_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, sample before the rising edge,
   // then advance the requirement model across that edge
   task automatic cyc(input string tag, input logic e, input logic f,
                      input logic t, input logic r, input logic h, input logic c);
      int  v;
      int  exp_d;
      logic exp_inv, clr;
      @(negedge clk);
      err_evt = e; freeze = f; tick_1s = t; rd_en = r; rd_hi = h; irq_clr = c;
      #1;
      s_data = int'(rd_data); s_inv = rd_invalid; s_irq = sec_irq;
      v = (!per_mode && !(f && m_frzq)) ? m_live : m_snap;
      exp_inv = r && (m_g != 0);
      exp_d = (r && !exp_inv) ? (h ? m_shadow : (v % 16)) : 0;
      if (r) begin
         chk(tag, s_data, exp_d);
         chk(tag, int'(s_inv), int'(exp_inv));
      end
      chk(tag, int'(s_irq), int'(m_irq));
      clr = (!per_mode && f && !m_frzq) || (per_mode && t);
      if (r && !exp_inv && !h) m_shadow = v / 16;
      if (clr) m_snap = m_live;
      if (clr) m_live = int'(e);
      else if (e && m_live != TOP) m_live = m_live + 1;
      if (per_mode && t) m_g = G;
      else if (m_g != 0) m_g = m_g - 1;
      if (per_mode && t) m_irq = 1'b1;
      else if (c) m_irq = 1'b0;
      m_frzq = f;
   endtask

   task automatic rd16(input string tag, input logic f, output int val);
      int lo;
      cyc(tag, 1'b0, f, 1'b0, 1'b1, 1'b0, 1'b0);
      lo = s_data;
      cyc(tag, 1'b0, f, 1'b0, 1'b1, 1'b1, 1'b0);
      val = s_data * 16 + lo;
   endtask

   initial begin
      #(4 * 200000);
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int v;
      int carry;
      int shd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd16("R1", 1'b0, v);
      chk("R1", v, 0);

      // R2 / R5: exhaustive count sweep past saturation
      for (int i = 1; i <= 300; i++) begin
         cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         rd16(i >= TOP ? "R5" : "R2", 1'b0, v);
         chk(i >= TOP ? "R5" : "R2", v, (i > TOP) ? TOP : i);
      end

      // R3: freeze capture, hold, release
      cyc("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 5; k++) begin
         cyc("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         rd16("R3", 1'b1, v);
         chk("R3", v, TOP);
      end
      cyc("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rd16("R3", 1'b0, v);
      chk("R3", v, 5);

      // R4: error on the freeze edge lands in the new interval
      cyc("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      rd16("R4", 1'b1, v);
      chk("R4", v, 5);
      cyc("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rd16("R4", 1'b0, v);
      chk("R4", v, 1);

      // R8: shadow keeps the upper half of the count seen at the low read
      for (int k = 0; k < 14; k++) cyc("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R8", s_data, 15);
      cyc("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R8", s_data, 0);
      rd16("R8", 1'b0, v);
      chk("R8", v, 16);

      // R7: strobe has no effect in host mode
      cyc("R7", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7", int'(s_irq), 0);
      rd16("R7", 1'b0, v);
      chk("R7", v, 17);

      // periodic mode
      per_mode = 1'b1;
      cyc("R6", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int j = 0; j < G; j++) cyc("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rd16("R6", 1'b0, v);
      chk("R6", v, 17);
      carry = 0;
      for (int n = 0; n < 12; n++) begin
         for (int k = 0; k < n; k++) cyc("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         shd = m_shadow;
         cyc("R6", n[0], 1'b0, 1'b1, 1'b0, 1'b0, (n == 3));
         for (int j = 1; j <= G; j++) begin
            cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            chk("R9", int'(s_inv), 1);
            chk("R9", s_data, 0);
            chk("R7", int'(s_irq), 1);
         end
         cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
         chk("R9", int'(s_inv), 0);
         chk("R9", s_data, shd);
         rd16("R6", 1'b0, v);
         chk("R6", v, carry + n);
         for (int k = 0; k < 3; k++) cyc("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         rd16("R6", 1'b0, v);
         chk("R6", v, carry + n);
         carry = int'(n[0]) + 3;
         cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
         cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         chk("R7", int'(s_irq), 0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule